// File: doc/BRIEF.md
# GPIO Edge Status and Event Router

This block watches sixteen general-purpose input pins. Each pin passes through a two-stage synchroniser, and the block then looks for one chosen edge on it. The edge can be rising or falling, selected per pin. A detected edge sets a sticky per-pin status bit. Software clears that bit by writing a one to it.

A per-pin mask decides which recorded edges count as a pending power-management event. All pending events are combined into one summary bit. A global routing bit sends the combined event into one of two summary hierarchies:

- **Management-interrupt path.** It has a second-level and a top-level status. Both fall automatically when a write to the pin status leaves nothing pending.
- **Control-interrupt path.** Its top-level status is sticky and is cleared only by its own write. Its output also needs a global enable.

A plain word-addressed read/write port gives software access to every register. Reads are combinational. A write takes effect at the next clock edge.

Top module: `gpio_evt_router`

## Requirements
- R1: After reset, every register reads zero and both `sci_irq` and `smi_irq` are low.
- R2: Address 0 is the event mask. Bits 15:0 are read/write, with bit n masking pin n. Bits 31:16 ignore writes and read zero. The same reserved-bit rule holds for addresses 1 and 2.
- R3: Address 2 selects the edge per pin: bit n = 0 picks a rising edge, 1 picks a falling edge. A pin change driven before clock edge k appears in the status register after edge k+2.
- R4: Address 1 is the pin status register. A write sets bit n to 0 where the write data has a 1. Where the write data has a 0, the bit is unchanged.
- R5: A status bit records its edge whatever its mask bit is. A pin counts as pending only when both its status bit and its mask bit are 1.
- R6: An edge that arrives in the same cycle as a clearing write to its status bit wins: the bit stays 1.
- R7: Address 5 bit 2 reads the OR of all pending pins.
- R8: Address 3 is the control register:
  - bit 0 is the route: 0 selects the control interrupt, 1 selects the management interrupt;
  - bit 1 is the global control-interrupt enable;
  - other bits read zero.
- R9: Management-interrupt path (address 5: bit 0 is the second level, bit 1 is the top level).
  - Both levels become 1 after any edge where the route is 1 and a pin is pending.
  - Any write to address 1 clears both levels in that cycle, unless a pin is still pending after the write.
  - `smi_irq` equals the top level while the route is 1.
- R10: Control-interrupt path (address 4 bit 0 is its top level).
  - The top level becomes 1 when the route is 0 and a pin is pending.
  - It is cleared only by writing 1 to address 4 bit 0, and setting wins over clearing.
  - Clearing pin status never clears it.
  - `sci_irq` is the top level ANDed with the enable and with route 0.
- R11: Addresses 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 16 | Asynchronous pin inputs |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sci_irq | output | 1 | Control-interrupt level output |
| smi_irq | output | 1 | Management-interrupt level output |

## Verification
The pin edge that sets a status bit and the software write that clears it can fall in the same cycle. The same holds for the control path's top-level set and its own clearing write.

The bench provokes the first collision directly. It writes the clear exactly two cycles after the pin toggles, which is the cycle in which the synchronised edge is seen. It then expects the bit to read 1 and the management levels to stay set.

Random traffic with frequent pin toggles and writes to addresses 1 and 4 produces many more such collisions. A cycle-by-cycle model in the bench judges each one, checking every readback and both interrupt outputs.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int NPIN = 16;
    localparam int DW   = 32;
    localparam int AW   = 3;

    localparam logic [AW-1:0] A_MASK = 3'd0;
    localparam logic [AW-1:0] A_STAT = 3'd1;
    localparam logic [AW-1:0] A_ESEL = 3'd2;
    localparam logic [AW-1:0] A_CTRL = 3'd3;
    localparam logic [AW-1:0] A_SCIT = 3'd4;
    localparam logic [AW-1:0] A_SUMM = 3'd5;

    typedef enum logic {
        ROUTE_SCI = 1'b0,
        ROUTE_SMI = 1'b1
    } route_e;

    typedef struct packed {
        logic   sci_en;
        route_e route;
    } ctrl_t;
endpackage

// File: rtl/gpio_pin_edge.sv
module gpio_pin_edge #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_async,
    input  logic [NPIN-1:0] fall_sel,
    output logic [NPIN-1:0] hit
);
    logic [NPIN-1:0] meta_q;
    logic [NPIN-1:0] sync_q;
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            if (fall_sel[i]) hit[i] = prev_q[i] & ~sync_q[i];
            else             hit[i] = sync_q[i] & ~prev_q[i];
        end
    end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] hit,
    input  logic [NPIN-1:0] clr,
    output logic [NPIN-1:0] st,
    output logic [NPIN-1:0] st_nxt
);
    for (genvar i = 0; i < NPIN; i++) begin : g_bit
        assign st_nxt[i] = hit[i] | (st[i] & ~clr[i]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= 1'b0;
            else        st[i] <= st_nxt[i];
        end
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & $past(clr & ~hit)) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & $past(hit)) == $past(hit))); // R6
endmodule

// File: rtl/gpio_evt_hier.sv
module gpio_evt_hier (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt,
    input  logic route_smi_nxt,
    input  logic stat_wr,
    input  logic sci_clr,
    output logic smi_l2,
    output logic smi_top,
    output logic sci_top
);
    logic smi_set, sci_set;

    assign smi_set = pend_nxt & route_smi_nxt;
    assign sci_set = pend_nxt & ~route_smi_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_l2  <= 1'b0;
            smi_top <= 1'b0;
            sci_top <= 1'b0;
        end else begin
            smi_l2  <= smi_set | (smi_l2 & ~stat_wr);
            smi_top <= smi_set | (smi_top & ~stat_wr);
            sci_top <= sci_set | (sci_top & ~sci_clr);
        end
    end

    AST_SMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !pend_nxt) |=> (!smi_l2 && !smi_top)); // R9
    AST_SCI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_top && !sci_clr) |=> sci_top); // R10
endmodule

// File: rtl/gpio_evt_router.sv
module gpio_evt_router
    import gpio_evt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   gpio_in,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          sci_irq,
    output logic          smi_irq
);
    localparam int PADW = DW - NPIN;

    logic [NPIN-1:0] mask_q, esel_q, hit, clr, st, st_nxt;
    logic [NPIN-1:0] mask_nxt;
    ctrl_t           ctrl_q, ctrl_nxt;
    logic            wr_mask, wr_stat, wr_esel, wr_ctrl, sci_clr;
    logic            pend_nxt, pme_sum;
    logic            smi_l2, smi_top, sci_top;

    assign wr_mask = bus_wr && (bus_addr == A_MASK);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_esel = bus_wr && (bus_addr == A_ESEL);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign sci_clr = bus_wr && (bus_addr == A_SCIT) && bus_wdata[0];

    assign mask_nxt = wr_mask ? bus_wdata[NPIN-1:0] : mask_q;
    assign ctrl_nxt = wr_ctrl ? ctrl_t'(bus_wdata[1:0]) : ctrl_q;
    assign clr      = wr_stat ? bus_wdata[NPIN-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            esel_q <= '0;
            ctrl_q <= '0;
        end else begin
            mask_q <= mask_nxt;
            ctrl_q <= ctrl_nxt;
            if (wr_esel) esel_q <= bus_wdata[NPIN-1:0];
        end
    end

    gpio_pin_edge #(.NPIN(NPIN)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (gpio_in),
        .fall_sel  (esel_q),
        .hit       (hit)
    );

    gpio_evt_status #(.NPIN(NPIN)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (clr),
        .st     (st),
        .st_nxt (st_nxt)
    );

    assign pend_nxt = |(st_nxt & mask_nxt);
    assign pme_sum  = |(st & mask_q);

    gpio_evt_hier u_hier (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_nxt      (pend_nxt),
        .route_smi_nxt (ctrl_nxt.route == ROUTE_SMI),
        .stat_wr       (wr_stat),
        .sci_clr       (sci_clr),
        .smi_l2        (smi_l2),
        .smi_top       (smi_top),
        .sci_top       (sci_top)
    );

    always_comb begin
        unique case (bus_addr)
            A_MASK:  bus_rdata = {{PADW{1'b0}}, mask_q};
            A_STAT:  bus_rdata = {{PADW{1'b0}}, st};
            A_ESEL:  bus_rdata = {{PADW{1'b0}}, esel_q};
            A_CTRL:  bus_rdata = {30'd0, ctrl_q};
            A_SCIT:  bus_rdata = {31'd0, sci_top};
            A_SUMM:  bus_rdata = {29'd0, pme_sum, smi_top, smi_l2};
            default: bus_rdata = '0;
        endcase
    end

    assign sci_irq = sci_top & ctrl_q.sci_en & (ctrl_q.route == ROUTE_SCI);
    assign smi_irq = smi_top & (ctrl_q.route == ROUTE_SMI);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr <= A_ESEL) |-> (bus_rdata[DW-1:NPIN] == '0)); // R2
    AST_PME_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !pme_sum); // R5
endmodule

// File: tb/gpio_evt_router_test.sv
module gpio_evt_router_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] gpio_in = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sci_irq, smi_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // bench model state
    logic [15:0] m_s1 = '0, m_s2 = '0, m_p = '0;
    logic [15:0] m_mask = '0, m_st = '0, m_esel = '0;
    logic        m_route = 1'b0, m_scien = 1'b0;
    logic        m_l2 = 1'b0, m_top = 1'b0, m_sci = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_evt_router uut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sci_irq(sci_irq), .smi_irq(smi_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'd0, m_mask};
            3'd1: return {16'd0, m_st};
            3'd2: return {16'd0, m_esel};
            3'd3: return {30'd0, m_scien, m_route};
            3'd4: return {31'd0, m_sci};
            3'd5: return {29'd0, |(m_st & m_mask), m_top, m_l2};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R3";
            3'd3: return "R8";
            3'd4: return "R10";
            3'd5: return "R7";
            default: return "R11";
        endcase
    endfunction

    // one cycle: called at a negedge; drives, checks, advances model
    task automatic step(input logic [15:0] pins, input logic wr,
                        input logic [2:0] a, input logic [31:0] wd);
        logic [15:0] hit, st_n, mask_n, clr;
        logic        route_n, pend, stwr, sciclr;
        gpio_in = pins; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        chk(addr_tag(a), bus_rdata, model_read(a));
        chk("R9 smi_irq", {31'd0, smi_irq}, {31'd0, m_top & m_route});
        chk("R10 sci_irq", {31'd0, sci_irq}, {31'd0, m_sci & m_scien & ~m_route});
        for (int i = 0; i < 16; i++)
            hit[i] = m_esel[i] ? (m_p[i] & ~m_s2[i]) : (m_s2[i] & ~m_p[i]);
        clr     = (wr && a == 3'd1) ? wd[15:0] : 16'd0;
        st_n    = hit | (m_st & ~clr);
        mask_n  = (wr && a == 3'd0) ? wd[15:0] : m_mask;
        route_n = (wr && a == 3'd3) ? wd[0] : m_route;
        pend    = |(st_n & mask_n);
        stwr    = wr && a == 3'd1;
        sciclr  = wr && a == 3'd4 && wd[0];
        @(posedge clk);
        m_l2  = (route_n & pend) | (m_l2 & ~stwr);
        m_top = (route_n & pend) | (m_top & ~stwr);
        m_sci = (~route_n & pend) | (m_sci & ~sciclr);
        m_st  = st_n; m_mask = mask_n; m_route = route_n;
        if (wr && a == 3'd3) m_scien = wd[1];
        if (wr && a == 3'd2) m_esel = wd[15:0];
        m_p = m_s2; m_s2 = m_s1; m_s1 = pins;
        @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] pins, input logic [2:0] a, output logic [31:0] v);
        gpio_in = pins; bus_wr = 1'b0; bus_addr = a; #1;
        v = bus_rdata;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [15:0] pins;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            bus_addr = a[2:0]; #1;
            chk("R1 reset read", bus_rdata, 32'd0);
        end
        chk("R1 irqs", {30'd0, sci_irq, smi_irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reserved bits read zero
        step(16'h0, 1'b1, 3'd0, 32'hFFFF_FFFF);
        rd(16'h0, 3'd0, v); chk("R2 mask reserved", v, 32'h0000_FFFF);
        step(16'h0, 1'b1, 3'd0, 32'h0000_0000);
        // R11: unmapped writes ignored
        step(16'h0, 1'b1, 3'd6, 32'hFFFF_FFFF);
        rd(16'h0, 3'd6, v); chk("R11 unmapped", v, 32'd0);

        // R5 and R3: unmasked rising edge on pin 3 recorded after edge k+2
        step(16'h0008, 1'b0, 3'd1, 32'd0);
        step(16'h0008, 1'b0, 3'd1, 32'd0);
        rd(16'h0008, 3'd1, v); chk("R3 not yet", v, 32'd0);
        step(16'h0008, 1'b0, 3'd1, 32'd0);
        rd(16'h0008, 3'd1, v); chk("R5 unmasked recorded", v, 32'h0008);
        rd(16'h0008, 3'd5, v); chk("R5 no pending", v, 32'd0);
        // R4: writing zeros keeps, writing one clears
        step(16'h0008, 1'b1, 3'd1, 32'h0000_0000);
        rd(16'h0008, 3'd1, v); chk("R4 zero write", v, 32'h0008);
        step(16'h0008, 1'b1, 3'd1, 32'h0000_0008);
        rd(16'h0008, 3'd1, v); chk("R4 one clears", v, 32'd0);

        // R9 and R6: route to SMI, mask pin 0, collide edge with clear
        step(16'h0008, 1'b1, 3'd3, 32'h1);
        step(16'h0008, 1'b1, 3'd0, 32'h1);
        step(16'h0009, 1'b0, 3'd0, 32'd0);
        step(16'h0009, 1'b0, 3'd0, 32'd0);
        step(16'h0009, 1'b0, 3'd0, 32'd0);
        rd(16'h0009, 3'd5, v); chk("R9 levels set", v, 32'h7);
        chk("R9 smi_irq", {31'd0, smi_irq}, 32'd1);
        step(16'h0009, 1'b1, 3'd1, 32'h1);
        rd(16'h0009, 3'd5, v); chk("R9 cleared with pin", v, 32'h0);
        step(16'h0008, 1'b0, 3'd0, 32'd0);
        step(16'h0008, 1'b0, 3'd0, 32'd0);
        step(16'h0008, 1'b0, 3'd0, 32'd0);
        step(16'h0009, 1'b0, 3'd0, 32'd0);
        step(16'h0009, 1'b0, 3'd0, 32'd0);
        step(16'h0009, 1'b1, 3'd1, 32'h1);  // edge seen this cycle
        rd(16'h0009, 3'd1, v); chk("R6 set wins", v, 32'h1);
        rd(16'h0009, 3'd5, v); chk("R6 levels stay", v, 32'h7);

        // R10: SCI route; pin clear does not clear top
        step(16'h0009, 1'b1, 3'd3, 32'h2);
        rd(16'h0009, 3'd4, v); chk("R10 sci top set", v, 32'h1);
        chk("R10 sci_irq", {31'd0, sci_irq}, 32'd1);
        step(16'h0009, 1'b1, 3'd1, 32'h1);
        step(16'h0009, 1'b0, 3'd0, 32'd0);
        rd(16'h0009, 3'd4, v); chk("R10 sticky", v, 32'h1);
        step(16'h0009, 1'b1, 3'd4, 32'h1);
        rd(16'h0009, 3'd4, v); chk("R10 own clear", v, 32'h0);
        // R3: falling edge select on pin 0
        step(16'h0009, 1'b1, 3'd2, 32'h1);
        step(16'h0008, 1'b0, 3'd0, 32'd0);
        step(16'h0008, 1'b0, 3'd0, 32'd0);
        step(16'h0008, 1'b0, 3'd0, 32'd0);
        rd(16'h0008, 3'd1, v); chk("R3 falling", v, 32'h1);

        // random phase with collisions, judged by the model (R4 R6 R9 R10)
        pins = 16'h0008;
        for (int n = 0; n < 4000; n++) begin
            logic        w;
            logic [2:0]  a;
            logic [31:0] d;
            if ($urandom_range(0, 2) == 0) pins = pins ^ (16'h1 << $urandom_range(0, 15));
            w = ($urandom_range(0, 9) < 4);
            a = 3'($urandom_range(0, 7));
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
            step(pins, w, a, d);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule